// File: doc/BRIEF.md
# Interrupt message forwarder

This block sits between the per-source interrupt state of an interrupt domain and the path that delivers message-signalled interrupts. It keeps a pending bit, an enable bit and a routing word for every source. When a source is both pending and enabled, and the domain-wide enable is on, the block turns it into one outgoing message. The message carries a hart index, a guest index and an interrupt identity, all taken from that source's routing word. Source 0 is reserved and never forwards.

Two things start a check. A source input event sets that source's pending bit, and the source is checked on the next cycle. Any register write queues a check of every source from 1 to NUM_SRC-1, taken in ascending order. Software can also write a message-generate register, which sends one message directly. The message goes out on a valid/ready channel. While `msg_valid` is high and `msg_ready` is low, the message fields hold steady and the scan waits on the current source. The pending bit of a forwarded source is cleared in the cycle the message is accepted. Turning the message into a memory write toward an interrupt file is done further down the path.

The register port is a plain write strobe with a combinational read. The word addresses are: 0x00 domain control (bit 0 enables the domain), 0x01 set-pending by source number, 0x02 clear-pending by number, 0x03 set-enable by number, 0x04 clear-enable by number, 0x05 message-generate, 0x06 pending vector (read only), 0x07 enable vector (read only), and 0x40+i routing word of source i. A routing word holds the identity in bits [10:0], the guest index in bits [17:12] and the hart index in bits [31:18].

Top module: `msg_forwarder`

## Requirements
- R1: After reset, no message is offered, and the domain control, pending vector, enable vector and every routing word read as 0.
- R2: While domain control bit 0 is clear, no source message is sent. Pending bits stay set, and enabling the domain later forwards them.
- R3: A source is forwarded only when its pending bit and its enable bit are both 1. The message carries the hart, guest and identity fields of its routing word, and the source's pending bit reads 0 once the message has been accepted.
- R4: A register write causes sources 1 to NUM_SRC-1 to be checked in ascending order, so sources that become eligible together leave in ascending source number.
- R5: A routing word write keeps bits [10:0], [17:12] and [31:18] and stores bit 11 as 0.
- R6: A write to the message-generate register sends one message with hart = data[31:18], identity = data[10:0] and guest 0. The register reads back the written value with bits [17:12] cleared.
- R7: A source input event on source i sets pending bit i, and the source is checked on the next cycle without any register write. If it is enabled and the domain is on, its message is sent.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, the message stays valid with unchanged fields, and the source's pending bit stays 1.
- R9: A check request that arrives while a message is stalled makes the scan start again from source 1 after that message is accepted, so a lower-numbered source that has become eligible goes ahead of higher ones still waiting.
- R10: Set-pending, clear-pending, set-enable and clear-enable by number act on the source named by the write data. Values 0 and NUM_SRC or more change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register word address for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Register word address for the combinational read |
| rd_data | output | 32 | Read data |
| evt_valid | input | 1 | Source input event strobe |
| evt_id | input | $clog2(NUM_SRC) | Source number of the event |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_hart | output | 14 | Hart index of the message |
| msg_guest | output | 6 | Guest index of the message |
| msg_eiid | output | 11 | Interrupt identity of the message |

## Verification
The assertions assume that the downstream side never withdraws the message on its own, and that `evt_id` always names a real source. They also assume the reset is held for at least one clock edge before any strobe, because the checker's one-cycle history registers only mean something after that. The bench drives every input one time unit after the rising edge and holds each strobe for exactly one cycle. It sends events only to sources below NUM_SRC. It lowers `msg_ready` only in the stall and restart scenarios, and it never lowers it while `msg_valid` is already high. This keeps the checker's view of the previous cycle's pending, enable and domain state in step with the cycle in which each message was loaded.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;

  localparam int WORD_W  = 32;
  localparam int EIID_W  = 11;
  localparam int GUEST_W = 6;
  localparam int HART_W  = 14;
  localparam int EIID_LSB  = 0;
  localparam int GUEST_LSB = 12;
  localparam int HART_LSB  = 18;

  localparam logic [WORD_W-1:0] GUEST_FIELD = {{(WORD_W-GUEST_LSB-GUEST_W){1'b0}},
                                              {GUEST_W{1'b1}}, {GUEST_LSB{1'b0}}};
  localparam logic [WORD_W-1:0] ROUTE_KEEP  = 32'hFFFF_F7FF;

  // register word addresses
  localparam logic [7:0] A_DOMAIN  = 8'h00;
  localparam logic [7:0] A_SETPEND = 8'h01;
  localparam logic [7:0] A_CLRPEND = 8'h02;
  localparam logic [7:0] A_SETEN   = 8'h03;
  localparam logic [7:0] A_CLREN   = 8'h04;
  localparam logic [7:0] A_GENMSG  = 8'h05;
  localparam logic [7:0] A_PENDVEC = 8'h06;
  localparam logic [7:0] A_ENVEC   = 8'h07;
  localparam logic [7:0] A_ROUTE   = 8'h40;

  typedef struct packed {
    logic [HART_W-1:0]  hart;
    logic [GUEST_W-1:0] guest;
    logic [EIID_W-1:0]  eiid;
  } fwd_msg_t;

  function automatic fwd_msg_t route_to_msg(input logic [WORD_W-1:0] w);
    fwd_msg_t m;
    m.hart  = w[HART_LSB +: HART_W];
    m.guest = w[GUEST_LSB +: GUEST_W];
    m.eiid  = w[EIID_LSB +: EIID_W];
    return m;
  endfunction

endpackage

// File: rtl/fwd_regs.sv
`timescale 1ns/1ps
module fwd_regs
  import fwd_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dom_on,
  output logic [NUM_SRC-1:0] en_vec,
  output logic [WORD_W-1:0] route [NUM_SRC],
  output logic [WORD_W-1:0] gen_word,
  output logic              gen_fire,
  output logic [NUM_SRC-1:0] wr_setpend,
  output logic [NUM_SRC-1:0] wr_clrpend
);

  logic is_seten, is_clren, is_setp, is_clrp;

  assign is_setp  = wr_en && (wr_addr == A_SETPEND);
  assign is_clrp  = wr_en && (wr_addr == A_CLRPEND);
  assign is_seten = wr_en && (wr_addr == A_SETEN);
  assign is_clren = wr_en && (wr_addr == A_CLREN);
  assign gen_fire = wr_en && (wr_addr == A_GENMSG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dom_on   <= 1'b0;
      gen_word <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_DOMAIN) dom_on <= wr_data[0];
      if (gen_fire) gen_word <= wr_data & ~GUEST_FIELD;
    end
  end

  assign en_vec[0]     = 1'b0;
  assign route[0]      = '0;
  assign wr_setpend[0] = 1'b0;
  assign wr_clrpend[0] = 1'b0;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
    logic hit_num, hit_route;
    assign hit_num   = (wr_data == WORD_W'(i));
    assign hit_route = wr_en && (wr_addr == A_ROUTE + 8'(i));
    assign wr_setpend[i] = is_setp && hit_num;
    assign wr_clrpend[i] = is_clrp && hit_num;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_vec[i] <= 1'b0;
        route[i]  <= '0;
      end else begin
        if (is_seten && hit_num)      en_vec[i] <= 1'b1;
        else if (is_clren && hit_num) en_vec[i] <= 1'b0;
        if (hit_route) route[i] <= wr_data & ROUTE_KEEP;
      end
    end
  end

endmodule

// File: rtl/fwd_pending.sv
`timescale 1ns/1ps
module fwd_pending #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] pend
);

  assign pend[0] = 1'b0;

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_bit
    // a set in the same cycle as a clear wins: a fresh event is not lost
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (set_vec[i]) pend[i] <= 1'b1;
      else if (clr_vec[i]) pend[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/fwd_engine.sv
`timescale 1ns/1ps
module fwd_engine
  import fwd_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dom_on,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en_vec,
  input  logic [WORD_W-1:0]  route [NUM_SRC],
  input  logic               rescan,
  input  logic [NUM_SRC-1:0] evt_chk,
  input  logic               gen_fire,
  input  logic [WORD_W-1:0]  gen_word,
  input  logic               msg_ready,
  output logic               msg_valid,
  output fwd_msg_t           msg,
  output logic               out_is_gen,
  output logic [IDW-1:0]     out_src,
  output logic [NUM_SRC-1:0] acc_clr
);

  localparam logic [NUM_SRC-1:0] SRC_ALL = {{(NUM_SRC-1){1'b1}}, 1'b0};

  logic [NUM_SRC-1:0] chk, take;
  logic               gen_pend;
  logic               pick_hit, free, load_gen, act, load_src, accept;
  logic [IDW-1:0]     pick_idx;

  // lowest numbered source with a check outstanding
  always_comb begin
    pick_hit = 1'b0;
    pick_idx = '0;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (chk[i]) begin
        pick_hit = 1'b1;
        pick_idx = IDW'(i);
      end
    end
  end

  assign accept   = msg_valid && msg_ready;
  assign free     = !msg_valid;
  assign load_gen = free && gen_pend;
  assign act      = free && !gen_pend && pick_hit;
  assign load_src = act && dom_on && pend[pick_idx] && en_vec[pick_idx];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_vec
    assign take[i]    = act && (pick_idx == IDW'(i));
    assign acc_clr[i] = accept && !out_is_gen && (out_src == IDW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk        <= '0;
      gen_pend   <= 1'b0;
      msg_valid  <= 1'b0;
      msg        <= '0;
      out_is_gen <= 1'b0;
      out_src    <= '0;
    end else begin
      chk <= ((chk & ~take) | evt_chk | (rescan ? SRC_ALL : '0)) & SRC_ALL;

      if (gen_fire)      gen_pend <= 1'b1;
      else if (load_gen) gen_pend <= 1'b0;

      if (accept) begin
        msg_valid <= 1'b0;
      end else if (load_gen) begin
        msg_valid  <= 1'b1;
        msg.hart   <= gen_word[HART_LSB +: HART_W];
        msg.guest  <= '0;
        msg.eiid   <= gen_word[EIID_LSB +: EIID_W];
        out_is_gen <= 1'b1;
        out_src    <= '0;
      end else if (load_src) begin
        msg_valid  <= 1'b1;
        msg        <= route_to_msg(route[pick_idx]);
        out_is_gen <= 1'b0;
        out_src    <= pick_idx;
      end
    end
  end

endmodule

// File: rtl/msg_forwarder.sv
`timescale 1ns/1ps
module msg_forwarder
  import fwd_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              evt_valid,
  input  logic [IDW-1:0]    evt_id,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [13:0]       msg_hart,
  output logic [5:0]        msg_guest,
  output logic [10:0]       msg_eiid
);

  logic               dom_on, gen_fire, out_is_gen;
  logic [NUM_SRC-1:0] en_vec, pend, wr_setpend, wr_clrpend, evt_hit, acc_clr;
  logic [WORD_W-1:0]  route [NUM_SRC];
  logic [WORD_W-1:0]  gen_word;
  logic [IDW-1:0]     out_src;
  fwd_msg_t           msg;

  assign evt_hit[0] = 1'b0;
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_evt
    assign evt_hit[i] = evt_valid && (evt_id == IDW'(i));
  end

  fwd_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dom_on(dom_on), .en_vec(en_vec), .route(route), .gen_word(gen_word),
    .gen_fire(gen_fire), .wr_setpend(wr_setpend), .wr_clrpend(wr_clrpend)
  );

  fwd_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_vec(wr_setpend | evt_hit),
    .clr_vec(wr_clrpend | acc_clr),
    .pend(pend)
  );

  fwd_engine #(.NUM_SRC(NUM_SRC)) u_eng (
    .clk(clk), .rst_n(rst_n), .dom_on(dom_on), .pend(pend), .en_vec(en_vec),
    .route(route), .rescan(wr_en), .evt_chk(evt_hit), .gen_fire(gen_fire),
    .gen_word(gen_word), .msg_ready(msg_ready), .msg_valid(msg_valid), .msg(msg),
    .out_is_gen(out_is_gen), .out_src(out_src), .acc_clr(acc_clr)
  );

  assign msg_hart  = msg.hart;
  assign msg_guest = msg.guest;
  assign msg_eiid  = msg.eiid;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_DOMAIN:  rd_data = {31'b0, dom_on};
      A_GENMSG:  rd_data = gen_word;
      A_PENDVEC: rd_data[NUM_SRC-1:0] = pend;
      A_ENVEC:   rd_data[NUM_SRC-1:0] = en_vec;
      default: begin
        for (int i = 1; i < NUM_SRC; i++)
          if (rd_addr == A_ROUTE + 8'(i)) rd_data = route[i];
      end
    endcase
  end

endmodule

// File: rtl/fwd_chk.sv
`timescale 1ns/1ps
module fwd_chk #(
  parameter int NUM_SRC = 32,
  localparam int IDW = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [13:0]        msg_hart,
  input logic [5:0]         msg_guest,
  input logic [10:0]        msg_eiid,
  input logic               dom_on,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] en_vec,
  input logic               out_is_gen,
  input logic [IDW-1:0]     out_src,
  input logic               evt_valid,
  input logic [IDW-1:0]     evt_id
);

  logic               prev_on;
  logic [NUM_SRC-1:0] prev_pend, prev_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_on   <= 1'b0;
      prev_pend <= '0;
      prev_en   <= '0;
    end else begin
      prev_on   <= dom_on;
      prev_pend <= pend;
      prev_en   <= en_vec;
    end
  end

  assert_domain_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && !out_is_gen) |-> prev_on);

  assert_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && !out_is_gen) |-> (prev_pend[out_src] && prev_en[out_src]));

  assert_guest_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && out_is_gen) |-> (msg_guest == 6'd0));

  assert_event_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_id != '0) |=> pend[$past(evt_id)]);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable({msg_hart, msg_guest, msg_eiid})));

endmodule

bind msg_forwarder fwd_chk #(.NUM_SRC(NUM_SRC)) u_fwd_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_hart(msg_hart), .msg_guest(msg_guest), .msg_eiid(msg_eiid),
  .dom_on(dom_on), .pend(pend), .en_vec(en_vec), .out_is_gen(out_is_gen),
  .out_src(out_src), .evt_valid(evt_valid), .evt_id(evt_id)
);

// File: tb/test_msg_forwarder.sv
`timescale 1ns/1ps
module test_msg_forwarder;

  localparam int NUM_SRC = 32;
  localparam int IDW = $clog2(NUM_SRC);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, evt_valid = 1'b0, msg_ready = 1'b1, msg_valid;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [IDW-1:0] evt_id = '0;
  logic [13:0] msg_hart;
  logic [5:0] msg_guest;
  logic [10:0] msg_eiid;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [30:0] log_q[$];

  always #2.5 clk = ~clk;

  msg_forwarder #(.NUM_SRC(NUM_SRC)) i_msg_forwarder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_valid(evt_valid), .evt_id(evt_id),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_hart(msg_hart),
    .msg_guest(msg_guest), .msg_eiid(msg_eiid)
  );

  always @(negedge clk)
    if (rst_n && msg_valid && msg_ready) log_q.push_back({msg_hart, msg_guest, msg_eiid});

  function automatic logic [30:0] mk(input logic [13:0] h, input logic [5:0] g, input logic [10:0] e);
    return {h, g, e};
  endfunction

  function automatic logic [31:0] rw(input logic [13:0] h, input logic [5:0] g, input logic [10:0] e);
    return {h, g, 1'b0, e};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_log(input int n, input int limit);
    for (int k = 0; k < limit && log_q.size() < n; k++) @(negedge clk);
    step(1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check(msg_valid == 1'b0, "R1 msg_valid", {31'b0, msg_valid}, 0);
    rd(8'h00, d); check(d == 0, "R1 domain", d, 0);
    rd(8'h06, d); check(d == 0, "R1 pending", d, 0);
    rd(8'h07, d); check(d == 0, "R1 enable", d, 0);
    rd(8'h45, d); check(d == 0, "R1 route5", d, 0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    log_q.delete();
    wr(8'h45, rw(14'd3, 6'd2, 11'h15));
    wr(8'h03, 32'd5);
    wr(8'h01, 32'd5);
    step(10);
    check(log_q.size() == 0, "R2 no msg while domain off", log_q.size(), 0);
    rd(8'h06, d); check(d == 32'h20, "R2 pending kept", d, 32'h20);
    wr(8'h01, 32'd0);
    wr(8'h01, 32'd40);
    wr(8'h03, 32'd32);
    rd(8'h06, d); check(d == 32'h20, "R10 out-of-range set ignored", d, 32'h20);
    rd(8'h07, d); check(d == 32'h20, "R10 out-of-range enable ignored", d, 32'h20);
    wr(8'h00, 32'd1);
    wait_log(1, 20);
    check(log_q.size() == 1, "R2 forwarded after enable", log_q.size(), 1);
    if (log_q.size() > 0)
      check(log_q[0] == mk(14'd3, 6'd2, 11'h15), "R3 fields", {1'b0, log_q[0]}, {1'b0, mk(14'd3, 6'd2, 11'h15)});
    rd(8'h06, d); check(d == 0, "R3 pending cleared", d, 0);
    log_q.delete();
    wr(8'h46, rw(14'd6, 6'd0, 11'h66));
    wr(8'h01, 32'd6);
    step(10);
    check(log_q.size() == 0, "R3 disabled source not sent", log_q.size(), 0);
    rd(8'h06, d); check(d == 32'h40, "R3 disabled stays pending", d, 32'h40);
    wr(8'h02, 32'd6);
    rd(8'h06, d); check(d == 0, "R10 clear by number", d, 0);
    wr(8'h04, 32'd5);
    rd(8'h07, d); check(d == 0, "R10 clear enable by number", d, 0);
  endtask

  task automatic t_order;
    log_q.delete();
    wr(8'h00, 32'd0);
    wr(8'h42, rw(14'd0, 6'd0, 11'd2));
    wr(8'h47, rw(14'd0, 6'd0, 11'd7));
    wr(8'h49, rw(14'd0, 6'd0, 11'd9));
    wr(8'h03, 32'd9); wr(8'h03, 32'd2); wr(8'h03, 32'd7);
    wr(8'h01, 32'd9); wr(8'h01, 32'd7); wr(8'h01, 32'd2);
    wr(8'h00, 32'd1);
    wait_log(3, 40);
    check(log_q.size() == 3, "R4 count", log_q.size(), 3);
    if (log_q.size() == 3) begin
      check(log_q[0][10:0] == 11'd2, "R4 first", {21'b0, log_q[0][10:0]}, 2);
      check(log_q[1][10:0] == 11'd7, "R4 second", {21'b0, log_q[1][10:0]}, 7);
      check(log_q[2][10:0] == 11'd9, "R4 third", {21'b0, log_q[2][10:0]}, 9);
    end
  endtask

  task automatic t_stall;
    logic [31:0] d;
    logic [30:0] held;
    int n;
    log_q.delete();
    msg_ready = 1'b0;
    wr(8'h4A, rw(14'h1234, 6'h3F, 11'h10A));
    wr(8'h03, 32'd10);
    wr(8'h01, 32'd10);
    n = 0;
    while (!msg_valid && n < 20) begin step(1); n++; end
    check(msg_valid == 1'b1, "R8 message offered", {31'b0, msg_valid}, 1);
    held = {msg_hart, msg_guest, msg_eiid};
    check(held == mk(14'h1234, 6'h3F, 11'h10A), "R3 stalled fields", {1'b0, held}, {1'b0, mk(14'h1234, 6'h3F, 11'h10A)});
    for (int k = 0; k < 6; k++) begin
      step(1);
      check(msg_valid && {msg_hart, msg_guest, msg_eiid} == held, "R8 hold", {1'b0, msg_hart, msg_guest, msg_eiid}, {1'b0, held});
    end
    rd(8'h06, d); check(d == 32'h400, "R8 pending while stalled", d, 32'h400);
    msg_ready = 1'b1;
    step(3);
    check(log_q.size() == 1, "R8 accepted once", log_q.size(), 1);
    rd(8'h06, d); check(d == 0, "R8 pending after accept", d, 0);
  endtask

  task automatic t_event;
    logic [31:0] d;
    log_q.delete();
    wr(8'h44, rw(14'd5, 6'd0, 11'h44));
    wr(8'h03, 32'd4);
    step(5);
    log_q.delete();
    evt_valid = 1'b1; evt_id = IDW'(4);
    step(1);
    evt_valid = 1'b0;
    wait_log(1, 5);
    check(log_q.size() == 1, "R7 event forwards", log_q.size(), 1);
    if (log_q.size() > 0)
      check(log_q[0] == mk(14'd5, 6'd0, 11'h44), "R7 event fields", {1'b0, log_q[0]}, {1'b0, mk(14'd5, 6'd0, 11'h44)});
    log_q.delete();
    evt_valid = 1'b1; evt_id = IDW'(11);
    step(1);
    evt_valid = 1'b0;
    step(6);
    check(log_q.size() == 0, "R7 disabled event no msg", log_q.size(), 0);
    rd(8'h06, d); check(d == 32'h800, "R7 event sets pending", d, 32'h800);
    wr(8'h02, 32'd11);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h43, 32'hFFFF_FFFF);
    rd(8'h43, d); check(d == 32'hFFFF_F7FF, "R5 route mask", d, 32'hFFFF_F7FF);
  endtask

  task automatic t_gen;
    logic [31:0] d, v;
    v = 32'hABCD_EFFF;
    log_q.delete();
    wr(8'h05, v);
    wait_log(1, 10);
    check(log_q.size() == 1, "R6 one message", log_q.size(), 1);
    if (log_q.size() > 0)
      check(log_q[0] == mk(v[31:18], 6'd0, v[10:0]), "R6 fields", {1'b0, log_q[0]}, {1'b0, mk(v[31:18], 6'd0, v[10:0])});
    rd(8'h05, d); check(d == (v & ~32'h0003_F000), "R6 stored", d, v & ~32'h0003_F000);
  endtask

  task automatic t_restart;
    log_q.delete();
    wr(8'h00, 32'd0);
    wr(8'h46, rw(14'd0, 6'd0, 11'd6));
    wr(8'h48, rw(14'd0, 6'd0, 11'd8));
    wr(8'h43, rw(14'd0, 6'd0, 11'd3));
    wr(8'h03, 32'd6); wr(8'h03, 32'd8); wr(8'h03, 32'd3);
    wr(8'h01, 32'd6); wr(8'h01, 32'd8);
    msg_ready = 1'b0;
    wr(8'h00, 32'd1);
    step(4);
    wr(8'h01, 32'd3);
    step(2);
    msg_ready = 1'b1;
    wait_log(3, 40);
    check(log_q.size() == 3, "R9 count", log_q.size(), 3);
    if (log_q.size() == 3) begin
      check(log_q[0][10:0] == 11'd6, "R9 stalled first", {21'b0, log_q[0][10:0]}, 6);
      check(log_q[1][10:0] == 11'd3, "R9 restart from low", {21'b0, log_q[1][10:0]}, 3);
      check(log_q[2][10:0] == 11'd8, "R9 then higher", {21'b0, log_q[2][10:0]}, 8);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_gate;
    t_order;
    t_stall;
    t_event;
    t_mask;
    t_gen;
    t_restart;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule